// File: doc/BRIEF.md
# Microcontroller Serial Bridge Port

This block sits on the device side of a four-wire serial link that a microcontroller clocks in software. The wires are a serial clock, a direction/framing line, a data-in line that also carries sync pulses, and a data-out line that also carries an active-low interrupt. All four wires are asynchronous to the system clock. Each input wire is synchronized and then filtered, so that short spikes never reach the protocol logic.

When the direction line is high, the microcontroller writes to the block. The first byte it sends is a control byte that names the target and the byte count. The block turns the bytes that follow into either IN FIFO write strobes with a position index or register write strobes. When the direction line is low, the microcontroller reads from the block. It first sends one or two sync pulses on the data-in line. The block then streams the status byte, the OUT count byte and the OUT FIFO bytes on the data-out line. The block also emits the clear pulses that the surrounding USB engine needs at the end of each transfer.

Top module: `mcu_link_port`

## Requirements
- R1: A level change on the serial clock, direction or data-in wire is accepted only after the synchronized wire has held the new level for FILT_STABLE consecutive system-clock samples (default 2). A one-cycle spike therefore has no effect: it adds no written bit and no read shift.
- R2: A rising edge on the direction line starts a write. The data-in wire is sampled on each rising serial-clock edge, LSB first. The first 8 bits form the control byte: bit 7 toggle, bits 6..4 target address, bits 3..0 byte count (0 to 8). After that byte, toggle is shown on `ctrl_toggle_o` and the count on `ctrl_count_o`.
- R3: Targets 000, 001 and 010 select the IN FIFOs of endpoints 0, 1 and 2. Each completed data byte gives one `in_wr_o` pulse, with `in_ep_o` equal to the endpoint and the byte on `wr_data_o`. `in_ptr_o` starts at 0 for each write and steps by one per byte, modulo 8, so a ninth byte lands on position 0 again.
- R4: Targets 100, 101 and 110 are registers. Each completed data byte gives one `reg_wr_o` pulse with `reg_addr_o` equal to the target and the byte on `wr_data_o`. No FIFO strobe is given.
- R5: Target 111 is the configuration register. No strobe is given while its bytes arrive. At the falling edge of the direction line, one `cfg_wr_o` pulse carries the last received byte on `cfg_data_o`.
- R6: A falling edge of the direction line that ends a write to a FIFO target gives one `in_done_clr_o` pulse, with `in_ep_o` naming the endpoint. A write to a register target, or a write whose control byte was never completed, gives none.
- R7: With the direction line low, the falling edge of the first data-in pulse loads the status byte, and its bit 0 appears on the data-out wire. Each falling serial-clock edge then presents the next bit, LSB first. The stream is the status byte, then the OUT count byte, then OUT FIFO bytes. Each FIFO byte is taken from `out_data_i` with one `out_pop_o` pulse at the moment it is loaded.
- R8: A second data-in pulse, given before any serial clock, starts the stream at the OUT count byte bit 0 and skips the status byte.
- R9: A rising edge on the direction line ends a read. If the OUT count byte had been loaded, the block gives one pulse on each of `out_done_clr_o` and `setup_clr_o`. A read that stopped within the status byte (7 or fewer clock falls after a single pulse) gives neither.
- R10: While the direction line is high, the data-out wire follows `irq_n_i`. While it is low and no read is active, the data-out wire shows `status_i[0]`.
- R11: After reset, all strobe and clear outputs are low, and the data-out wire shows `status_i[0]` with all input wires held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the microcontroller (raw) |
| sin_i | input | 1 | Direction and framing line (raw) |
| sdi_i | input | 1 | Data-in and sync pulse line (raw) |
| sdo_o | output | 1 | Data-out bit or active-low interrupt |
| irq_n_i | input | 1 | Active-low interrupt to present while writing |
| status_i | input | 8 | Current status byte |
| outcnt_i | input | 8 | Current OUT count byte |
| out_data_i | input | 8 | Head byte of the OUT FIFO |
| out_pop_o | output | 1 | Pulse: OUT FIFO head byte consumed |
| ctrl_toggle_o | output | 1 | Toggle bit of the last control byte |
| ctrl_count_o | output | 4 | Byte count of the last control byte |
| in_wr_o | output | 1 | Pulse: write `wr_data_o` into an IN FIFO |
| in_ep_o | output | 2 | Endpoint of the current or last write target |
| in_ptr_o | output | 3 | FIFO position of the byte being written |
| wr_data_o | output | 8 | Last completed data byte |
| reg_wr_o | output | 1 | Pulse: write `wr_data_o` into register `reg_addr_o` |
| reg_addr_o | output | 3 | Target address of the last control byte |
| cfg_wr_o | output | 1 | Pulse: apply `cfg_data_o` to the configuration register |
| cfg_data_o | output | 8 | Pending configuration byte |
| in_done_clr_o | output | 1 | Pulse: clear IN done for endpoint `in_ep_o` |
| out_done_clr_o | output | 1 | Pulse: clear OUT done |
| setup_clr_o | output | 1 | Pulse: clear the setup flag |

## Verification
A wire change is seen by the protocol logic about four clocks later: two synchronizer stages plus two filter samples. Write strobes and clear pulses follow one clock after that. A new data-out bit is due about five clocks after the serial clock falls. The bench holds every wire level for eight clocks and samples the data-out wire only at the end of each hold. It logs the one-cycle strobes on falling clock edges, so each result is counted once, whatever its exact cycle. The sweeps cover every FIFO endpoint with every byte count from 0 to 8, plus an overrun. Reads are stopped on both sides of the status-byte boundary.

// File: rtl/mcu_link_pkg.sv
package mcu_link_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int NUM_WIRES = 3;

    // wire slots in the filtered vectors
    localparam int W_SCK = 0;
    localparam int W_SIN = 1;
    localparam int W_SDI = 2;

    localparam logic [2:0] TGT_CONFIG = 3'b111;

    typedef struct packed {
        logic       toggle;
        logic [2:0] addr;
        logic [3:0] count;
    } ctrl_t;

    typedef enum logic [1:0] {
        SRC_STATUS = 2'd0,
        SRC_COUNT  = 2'd1,
        SRC_FIFO   = 2'd2
    } rd_src_e;

    function automatic logic tgt_is_fifo(input logic [2:0] a);
        return a < 3'd3;
    endfunction

    function automatic logic tgt_is_reg(input logic [2:0] a);
        return a[2] && (a != TGT_CONFIG);
    endfunction

endpackage

// File: rtl/link_filter.sv
module link_filter #(
    parameter int STABLE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;

    typedef struct packed {
        logic [1:0]    sync;
        logic          lvl;
        logic [CW-1:0] cnt;
        logic          rise;
        logic          fall;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw_i};
        d.rise = 1'b0;
        d.fall = 1'b0;
        if (q.sync[1] != q.lvl) begin
            if (q.cnt == CW'(STABLE - 1)) begin
                d.lvl  = q.sync[1];
                d.cnt  = '0;
                d.rise = q.sync[1];
                d.fall = !q.sync[1];
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl_o  = q.lvl;
    assign rise_o = q.rise;
    assign fall_o = q.fall;
endmodule

// File: rtl/mcu_wr_deframer.sv
module mcu_wr_deframer
    import mcu_link_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    localparam int PTR_W = $clog2(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sin_rise_i,
    input  logic              sin_fall_i,
    input  logic              sck_rise_i,
    input  logic              sdi_lvl_i,
    output ctrl_t             ctrl_o,
    output logic              in_wr_o,
    output logic [PTR_W-1:0]  in_ptr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              reg_wr_o,
    output logic              cfg_wr_o,
    output logic [BYTE_W-1:0] cfg_data_o,
    output logic              in_done_clr_o
);
    typedef struct packed {
        logic                 active;
        logic                 have_ctrl;
        logic [BIT_CNT_W-1:0] bitcnt;
        logic [BYTE_W-1:0]    shreg;
        ctrl_t                ctrl;
        logic [PTR_W-1:0]     ptr;
        logic [PTR_W-1:0]     wr_ptr;
        logic [BYTE_W-1:0]    wr_data;
        logic                 cfg_pend;
        logic [BYTE_W-1:0]    cfg_data;
        logic                 in_wr;
        logic                 reg_wr;
        logic                 cfg_wr;
        logic                 done_clr;
    } wr_t;

    wr_t q, d;
    logic [BYTE_W-1:0] byte_nxt;

    assign byte_nxt = {sdi_lvl_i, q.shreg[BYTE_W-1:1]};

    always_comb begin
        d          = q;
        d.in_wr    = 1'b0;
        d.reg_wr   = 1'b0;
        d.cfg_wr   = 1'b0;
        d.done_clr = 1'b0;
        if (sin_rise_i) begin
            d.active    = 1'b1;
            d.have_ctrl = 1'b0;
            d.bitcnt    = '0;
            d.ptr       = '0;
            d.cfg_pend  = 1'b0;
        end else if (sin_fall_i && q.active) begin
            d.active = 1'b0;
            if (q.have_ctrl && tgt_is_fifo(q.ctrl.addr)) d.done_clr = 1'b1;
            if (q.cfg_pend) d.cfg_wr = 1'b1;
        end else if (sck_rise_i && q.active) begin
            d.shreg  = byte_nxt;
            d.bitcnt = q.bitcnt + BIT_CNT_W'(1);
            if (q.bitcnt == BIT_CNT_W'(BYTE_W - 1)) begin
                if (!q.have_ctrl) begin
                    d.ctrl      = ctrl_t'(byte_nxt);
                    d.have_ctrl = 1'b1;
                end else begin
                    d.wr_data = byte_nxt;
                    if (tgt_is_fifo(q.ctrl.addr)) begin
                        d.in_wr  = 1'b1;
                        d.wr_ptr = q.ptr;
                        d.ptr    = q.ptr + PTR_W'(1);
                    end else if (q.ctrl.addr == TGT_CONFIG) begin
                        d.cfg_pend = 1'b1;
                        d.cfg_data = byte_nxt;
                    end else if (tgt_is_reg(q.ctrl.addr)) begin
                        d.reg_wr = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl_o        = q.ctrl;
    assign in_wr_o       = q.in_wr;
    assign in_ptr_o      = q.wr_ptr;
    assign wr_data_o     = q.wr_data;
    assign reg_wr_o      = q.reg_wr;
    assign cfg_wr_o      = q.cfg_wr;
    assign cfg_data_o    = q.cfg_data;
    assign in_done_clr_o = q.done_clr;
endmodule

// File: rtl/mcu_rd_streamer.sv
module mcu_rd_streamer
    import mcu_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sin_lvl_i,
    input  logic              sin_rise_i,
    input  logic              sck_lvl_i,
    input  logic              sck_fall_i,
    input  logic              sdi_rise_i,
    input  logic              sdi_fall_i,
    input  logic [BYTE_W-1:0] status_i,
    input  logic [BYTE_W-1:0] outcnt_i,
    input  logic [BYTE_W-1:0] out_data_i,
    output logic              busy_o,
    output logic              bit_o,
    output logic              pop_o,
    output logic              clr_o
);
    typedef struct packed {
        logic [1:0]           pulses;
        logic                 hi_seen;
        logic                 started;
        logic [BIT_CNT_W-1:0] bitcnt;
        logic [BYTE_W-1:0]    shreg;
        rd_src_e              src;
        logic                 past;
        logic                 pop;
        logic                 clr;
    } rd_t;

    rd_t q, d;

    always_comb begin
        d     = q;
        d.pop = 1'b0;
        d.clr = 1'b0;
        if (sin_rise_i) begin
            d.clr     = q.past;
            d.pulses  = '0;
            d.hi_seen = 1'b0;
            d.started = 1'b0;
            d.past    = 1'b0;
        end else if (!sin_lvl_i) begin
            if (sdi_rise_i && !sck_lvl_i && !q.started) begin
                d.hi_seen = 1'b1;
            end else if (sdi_fall_i && q.hi_seen) begin
                d.hi_seen = 1'b0;
                d.bitcnt  = '0;
                if (q.pulses == 2'd0) begin
                    d.pulses = 2'd1;
                    d.shreg  = status_i;
                    d.src    = SRC_STATUS;
                end else if (q.pulses == 2'd1) begin
                    d.pulses = 2'd2;
                    d.shreg  = outcnt_i;
                    d.src    = SRC_COUNT;
                    d.past   = 1'b1;
                end
            end else if (sck_fall_i && q.pulses != 2'd0) begin
                d.started = 1'b1;
                if (q.bitcnt == BIT_CNT_W'(BYTE_W - 1)) begin
                    d.bitcnt = '0;
                    if (q.src == SRC_STATUS) begin
                        d.shreg = outcnt_i;
                        d.src   = SRC_COUNT;
                        d.past  = 1'b1;
                    end else begin
                        d.shreg = out_data_i;
                        d.src   = SRC_FIFO;
                        d.pop   = 1'b1;
                    end
                end else begin
                    d.shreg  = q.shreg >> 1;
                    d.bitcnt = q.bitcnt + BIT_CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.pulses != 2'd0);
    assign bit_o  = q.shreg[0];
    assign pop_o  = q.pop;
    assign clr_o  = q.clr;
endmodule

// File: rtl/mcu_link_port.sv
module mcu_link_port
    import mcu_link_pkg::*;
#(
    parameter int FILT_STABLE = 2,
    parameter int FIFO_DEPTH  = 8,
    localparam int PTR_W = $clog2(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              sin_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    input  logic              irq_n_i,
    input  logic [7:0]        status_i,
    input  logic [7:0]        outcnt_i,
    input  logic [7:0]        out_data_i,
    output logic              out_pop_o,
    output logic              ctrl_toggle_o,
    output logic [3:0]        ctrl_count_o,
    output logic              in_wr_o,
    output logic [1:0]        in_ep_o,
    output logic [PTR_W-1:0]  in_ptr_o,
    output logic [7:0]        wr_data_o,
    output logic              reg_wr_o,
    output logic [2:0]        reg_addr_o,
    output logic              cfg_wr_o,
    output logic [7:0]        cfg_data_o,
    output logic              in_done_clr_o,
    output logic              out_done_clr_o,
    output logic              setup_clr_o
);
    logic [NUM_WIRES-1:0] raw, lvl, rise, fall;
    assign raw = {sdi_i, sin_i, sck_i};

    for (genvar g = 0; g < NUM_WIRES; g++) begin : g_filt
        link_filter #(.STABLE(FILT_STABLE)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw[g]),
            .lvl_o  (lvl[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    ctrl_t ctrl;
    logic  rd_busy, rd_bit, rd_clr;

    mcu_wr_deframer #(.FIFO_DEPTH(FIFO_DEPTH)) u_wr (
        .clk           (clk),
        .rst_n         (rst_n),
        .sin_rise_i    (rise[W_SIN]),
        .sin_fall_i    (fall[W_SIN]),
        .sck_rise_i    (rise[W_SCK]),
        .sdi_lvl_i     (lvl[W_SDI]),
        .ctrl_o        (ctrl),
        .in_wr_o       (in_wr_o),
        .in_ptr_o      (in_ptr_o),
        .wr_data_o     (wr_data_o),
        .reg_wr_o      (reg_wr_o),
        .cfg_wr_o      (cfg_wr_o),
        .cfg_data_o    (cfg_data_o),
        .in_done_clr_o (in_done_clr_o)
    );

    mcu_rd_streamer u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sin_lvl_i  (lvl[W_SIN]),
        .sin_rise_i (rise[W_SIN]),
        .sck_lvl_i  (lvl[W_SCK]),
        .sck_fall_i (fall[W_SCK]),
        .sdi_rise_i (rise[W_SDI]),
        .sdi_fall_i (fall[W_SDI]),
        .status_i   (status_i),
        .outcnt_i   (outcnt_i),
        .out_data_i (out_data_i),
        .busy_o     (rd_busy),
        .bit_o      (rd_bit),
        .pop_o      (out_pop_o),
        .clr_o      (rd_clr)
    );

    assign ctrl_toggle_o  = ctrl.toggle;
    assign ctrl_count_o   = ctrl.count;
    assign in_ep_o        = ctrl.addr[1:0];
    assign reg_addr_o     = ctrl.addr;
    assign out_done_clr_o = rd_clr;
    assign setup_clr_o    = rd_clr;
    assign sdo_o = lvl[W_SIN] ? irq_n_i : (rd_busy ? rd_bit : status_i[0]);
endmodule

// File: rtl/mcu_link_port_chk.sv
module mcu_link_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_wr_o,
    input logic [1:0] in_ep_o,
    input logic       reg_wr_o,
    input logic [2:0] reg_addr_o,
    input logic       cfg_wr_o,
    input logic       in_done_clr_o,
    input logic       out_pop_o,
    input logic       out_done_clr_o
);
    a_r3_fifo_endpoint: assert property (@(posedge clk) disable iff (!rst_n)
        in_wr_o |-> in_ep_o != 2'b11);

    a_r4_reg_target: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> (reg_addr_o[2] && reg_addr_o != 3'b111));

    a_r5_cfg_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |=> !cfg_wr_o);

    a_r6_done_endpoint: assert property (@(posedge clk) disable iff (!rst_n)
        in_done_clr_o |-> in_ep_o != 2'b11);

    a_r7_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_pop_o |=> !out_pop_o);

    a_r9_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_done_clr_o |=> !out_done_clr_o);

    a_r11_one_write_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_wr_o, reg_wr_o, cfg_wr_o}));
endmodule

bind mcu_link_port mcu_link_port_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_wr_o        (in_wr_o),
    .in_ep_o        (in_ep_o),
    .reg_wr_o       (reg_wr_o),
    .reg_addr_o     (reg_addr_o),
    .cfg_wr_o       (cfg_wr_o),
    .in_done_clr_o  (in_done_clr_o),
    .out_pop_o      (out_pop_o),
    .out_done_clr_o (out_done_clr_o)
);

// File: tb/mcu_link_port_bench.sv
module mcu_link_port_bench;
    localparam int H = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, sin = 1'b0, sdi = 1'b0, irq_n = 1'b1;
    logic [7:0] status_v = 8'h00, outcnt_v = 8'h00, fifo_data;
    logic sdo, out_pop, tog, in_wr, reg_wr, cfg_wr, done_clr, odc, sclr;
    logic [3:0] cnt;
    logic [1:0] ep;
    logic [2:0] ptr, raddr;
    logic [7:0] wdata, cdata;

    int total = 0, bad = 0, finished = 0;
    int n_inwr = 0, n_reg = 0, n_cfg = 0, n_done = 0, n_odc = 0, n_sc = 0, n_pop = 0;
    logic [1:0] ev_ep [64];
    logic [2:0] ev_ptr [64];
    logic [7:0] ev_dat [64];
    logic [2:0] last_raddr;
    logic [7:0] last_rdata, last_cfg;
    logic [1:0] last_done_ep;

    always #2 clk = ~clk;

    function automatic logic [7:0] fifo_mem(input int i);
        return 8'(i * 29 + 60);
    endfunction
    assign fifo_data = fifo_mem(n_pop);

    mcu_link_port u_mcu_link_port (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sin_i(sin), .sdi_i(sdi), .sdo_o(sdo),
        .irq_n_i(irq_n), .status_i(status_v), .outcnt_i(outcnt_v), .out_data_i(fifo_data),
        .out_pop_o(out_pop), .ctrl_toggle_o(tog), .ctrl_count_o(cnt), .in_wr_o(in_wr),
        .in_ep_o(ep), .in_ptr_o(ptr), .wr_data_o(wdata), .reg_wr_o(reg_wr),
        .reg_addr_o(raddr), .cfg_wr_o(cfg_wr), .cfg_data_o(cdata),
        .in_done_clr_o(done_clr), .out_done_clr_o(odc), .setup_clr_o(sclr)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (in_wr) begin
                ev_ep[n_inwr % 64] = ep; ev_ptr[n_inwr % 64] = ptr; ev_dat[n_inwr % 64] = wdata;
                n_inwr++;
            end
            if (reg_wr) begin last_raddr = raddr; last_rdata = wdata; n_reg++; end
            if (cfg_wr) begin last_cfg = cdata; n_cfg++; end
            if (done_clr) begin last_done_ep = ep; n_done++; end
            if (odc) n_odc++;
            if (sclr) n_sc++;
            if (out_pop) n_pop++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch);
        if (glitch) begin
            sck = 1'b1; hold(1); sck = 1'b0; hold(H);
        end
        for (int i = 0; i < 8; i++) begin
            sdi = b[i]; hold(H);
            sck = 1'b1; hold(H);
            sck = 1'b0; hold(H);
        end
    endtask

    task automatic wr_start(input logic [7:0] c);
        sin = 1'b1; hold(H);
        send_byte(c, 1'b0);
    endtask

    task automatic wr_end();
        sdi = 1'b0; hold(H);
        sin = 1'b0; hold(2 * H);
    endtask

    task automatic rd_clock();
        sck = 1'b1; hold(H);
        sck = 1'b0; hold(H);
    endtask

    // R7 / R8: read stream of nf clock falls after np sync pulses
    task automatic rd_run(input int np, input int nf, input string req);
        int base, mism, off, idx, exp_pops;
        logic [7:0] eb;
        base = n_pop; mism = 0; off = (np == 2) ? 8 : 0;
        sin = 1'b0; hold(2 * H);
        for (int p = 0; p < np; p++) begin
            sdi = 1'b1; hold(H); sdi = 1'b0; hold(H);
        end
        for (int f = 0; f <= nf; f++) begin
            if (f > 0) rd_clock();
            idx = f + off;
            eb = (idx / 8 == 0) ? status_v : (idx / 8 == 1) ? outcnt_v : fifo_mem(base + idx / 8 - 2);
            if (sdo !== eb[idx % 8]) mism++;
        end
        chk(mism == 0, req, mism, 0);
        exp_pops = ((nf + off) / 8 > 1) ? (nf + off) / 8 - 1 : 0;
        chk(n_pop - base == exp_pops, {req, " pops"}, n_pop - base, exp_pops);
    endtask

    task automatic rd_end(input int exp_clr);
        int o0, s0;
        o0 = n_odc; s0 = n_sc;
        sin = 1'b1; hold(2 * H);
        chk(n_odc - o0 == exp_clr, "R9 out done clear", n_odc - o0, exp_clr);
        chk(n_sc - s0 == exp_clr, "R9 setup clear", n_sc - s0, exp_clr);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (finished == 0) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int b0, d0, r0, c0, mism;
        logic [7:0] c, dv;
        hold(5);
        rst_n = 1'b1;
        hold(4 * H);
        // R11: reset state
        chk({in_wr, reg_wr, cfg_wr, done_clr, odc, sclr, out_pop} == 7'd0, "R11 strobes", 0, 0);
        chk(sdo == status_v[0], "R11 sdo", sdo, status_v[0]);
        // R10: idle low shows status bit 0
        status_v = 8'h01; hold(2);
        chk(sdo == 1'b1, "R10 idle status bit", sdo, 1);
        status_v = 8'h02; hold(2);
        chk(sdo == 1'b0, "R10 idle status bit", sdo, 0);

        // R7/R9 reads around the status boundary
        status_v = 8'hA5; outcnt_v = 8'h53;
        rd_run(1, 3, "R7 short status");  rd_end(0);
        rd_run(1, 7, "R7 full status");   rd_end(0);
        rd_run(1, 8, "R7 count bit0");    rd_end(1);
        status_v = 8'h6E; outcnt_v = 8'h98;
        rd_run(1, 31, "R7 fifo stream");  rd_end(1);
        rd_run(2, 0, "R8 skip status");   rd_end(1);
        rd_run(2, 20, "R8 fifo stream");  rd_end(1);

        // R10: sin high follows interrupt
        irq_n = 1'b0; hold(2);
        chk(sdo == 1'b0, "R10 irq low", sdo, 0);
        irq_n = 1'b1; hold(2);
        chk(sdo == 1'b1, "R10 irq high", sdo, 1);
        sin = 1'b0; hold(2 * H);

        // R2/R3/R6: sweep every FIFO endpoint and byte count
        for (int e = 0; e < 3; e++) begin
            for (int n = 0; n <= 9; n++) begin
                int nb;
                nb = (n == 9) ? 10 : n;
                c = {n[0], 3'(e), 4'((n > 8) ? 8 : n)};
                b0 = n_inwr; d0 = n_done; r0 = n_reg;
                wr_start(c);
                for (int i = 0; i < nb; i++) send_byte(8'(e * 40 + n * 7 + i * 13 + 1), 1'b0);
                wr_end();
                chk(n_inwr - b0 == nb, "R3 byte strobes", n_inwr - b0, nb);
                mism = 0;
                for (int i = 0; i < nb; i++) begin
                    if (ev_ep[(b0 + i) % 64] != 2'(e)) mism++;
                    if (ev_ptr[(b0 + i) % 64] != 3'(i % 8)) mism++;
                    if (ev_dat[(b0 + i) % 64] != 8'(e * 40 + n * 7 + i * 13 + 1)) mism++;
                end
                chk(mism == 0, "R3 endpoint position data", mism, 0);
                chk(n_done - d0 == 1 && last_done_ep == 2'(e), "R6 in done clear",
                    n_done - d0, 1);
                chk(n_reg == r0, "R4 no reg strobe on fifo", n_reg - r0, 0);
                chk(tog == n[0] && cnt == 4'((n > 8) ? 8 : n), "R2 control fields",
                    {27'd0, tog, cnt}, {27'd0, n[0], 4'((n > 8) ? 8 : n)});
            end
        end

        // R4: register targets
        for (int a = 4; a < 7; a++) begin
            dv = 8'(a * 37 + 5);
            r0 = n_reg; d0 = n_done; b0 = n_inwr;
            wr_start({1'b0, 3'(a), 4'd1});
            send_byte(dv, 1'b0);
            wr_end();
            chk(n_reg - r0 == 1 && last_raddr == 3'(a) && last_rdata == dv, "R4 register write",
                {24'd0, last_rdata}, {24'd0, dv});
            chk(n_done == d0 && n_inwr == b0, "R6 no done clear on register", n_done - d0, 0);
        end

        // R5: configuration deferred to end of write
        c0 = n_cfg;
        wr_start({1'b0, 3'b111, 4'd2});
        send_byte(8'h3A, 1'b0);
        send_byte(8'hC6, 1'b0);
        hold(2 * H);
        chk(n_cfg == c0, "R5 no early config", n_cfg - c0, 0);
        wr_end();
        chk(n_cfg - c0 == 1 && last_cfg == 8'hC6, "R5 config at end",
            {24'd0, last_cfg}, 32'hC6);

        // R1: one-cycle spike on serial clock adds no bit
        b0 = n_inwr;
        wr_start({1'b0, 3'b001, 4'd2});
        send_byte(8'h96, 1'b1);
        send_byte(8'h4B, 1'b1);
        wr_end();
        chk(n_inwr - b0 == 2 && ev_dat[b0 % 64] == 8'h96 && ev_dat[(b0 + 1) % 64] == 8'h4B,
            "R1 spike rejected", {24'd0, ev_dat[b0 % 64]}, 32'h96);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule